// File: doc/BRIEF.md
# Debug Command Byte Processor

This block interprets the command stream that a debug host sends to an on-chip debug unit. Bytes arrive one at a time on a valid/ready receive channel. The block reads each opcode and then does one of two things. For a write command it collects the data bytes that follow. For a read command it places the response bytes, one per handshake, on a byte-wide valid/ready transmit channel. Serial line coding, instruction execution and breakpoint matching are handled outside this block. The block only raises a one-cycle strobe when an execute command arrives.

The block holds three registers: the debug control register, the 16-bit debug counter and a registered copy of the status inputs. It also holds a fixed revision word. Two inputs set the access rules. A debug-mode flag decides whether counter writes take effect and what a counter read returns. A read-protect strap stops the debug-mode bit of the control register from being cleared once it has been set.

Top module: `dbg_cmd_proc`

## Requirements
- R1: After reset the control register reads 00H, the counter reads 0000H, `tx_valid` is low, `rx_ready` is high and `exec_pulse` is low.
- R2: Opcode 00H returns two bytes: the revision word (default 0102H) high byte first, then the low byte.
- R3: Opcode 01H consumes two bytes, high then low. They load the counter only if `dbg_active` is high when the low byte is accepted; otherwise the counter keeps its value.
- R4: Opcode 02H returns one byte, the status register. The status register is `stat_in` registered every clock.
- R5: Opcode 03H returns two bytes, high byte first. In debug mode they are the bitwise inverse of the counter. When `dbg_active` is low they are FFH, FFH.
- R6: Opcode 04H consumes one byte and writes it to the control register, whichever state `dbg_active` is in.
- R7: Bit 7 of the control register is the debug-mode bit. While `rd_protect` is high, a control write cannot clear that bit once it is 1, though it can set it. While `rd_protect` is low, the bit can be cleared.
- R8: Opcode 12H consumes no data and returns nothing. It raises `exec_pulse` for exactly one cycle, in the cycle after the opcode is accepted.
- R9: Every other opcode (05H to 11H, 13H to FFH) is consumed with no data bytes and no response. The next byte is then taken as an opcode.
- R10: A response byte holds `tx_valid` high and `tx_data` stable until `tx_ready` accepts it. `rx_ready` stays low from the moment a response starts until its last byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | Host byte available |
| rx_ready | output | 1 | Block can accept a byte |
| rx_data | input | 8 | Host byte (opcode or data) |
| tx_valid | output | 1 | Response byte available |
| tx_ready | input | 1 | Host accepts the response byte |
| tx_data | output | 8 | Response byte |
| dbg_active | input | 1 | Device is in debug mode |
| rd_protect | input | 1 | Read-protect strap |
| stat_in | input | 8 | Status bits captured into the status register |
| ctl_q | output | 8 | Control register, bit 7 is the debug-mode bit |
| cnt_q | output | 16 | Counter register |
| exec_pulse | output | 1 | One-cycle strobe for the execute command |

## Verification
A corrupted parser state shows up at the ports right away. Either `rx_ready` drops with no response queued, or a data byte is taken as an opcode and the next response has the wrong length or contents. Any of these appears within one command. A wrong counter or control value stays hidden until the host reads it back, so every write in the stimulus is followed by a read or a check of the register port. This covers writes that are dropped and writes that are protected as well as writes that take effect. A response shift register that advances without a handshake shows up as changed `tx_data` during a stall, so response bytes are stalled for several cycles before they are accepted.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int DBG_BIT = BYTE_W - 1;
  localparam int LEFT_W  = 2;

  localparam logic [BYTE_W-1:0] OP_REV   = 8'h00;
  localparam logic [BYTE_W-1:0] OP_WCNT  = 8'h01;
  localparam logic [BYTE_W-1:0] OP_RSTAT = 8'h02;
  localparam logic [BYTE_W-1:0] OP_RCNT  = 8'h03;
  localparam logic [BYTE_W-1:0] OP_WCTL  = 8'h04;
  localparam logic [BYTE_W-1:0] OP_EXEC  = 8'h12;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_CNT_HI,
    PS_CNT_LO,
    PS_CTL,
    PS_SEND
  } pstate_e;

  typedef enum logic [1:0] {
    RS_REV,
    RS_STAT,
    RS_CNT
  } rsel_e;
endpackage

// File: rtl/dbg_cmd_parser.sv
module dbg_cmd_parser
  import dbg_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              tx_done,
  output logic              resp_load,
  output rsel_e             resp_sel,
  output logic              hi_ld,
  output logic              cnt_wr,
  output logic              ctl_wr,
  output logic              exec_pulse
);
  pstate_e state_q, state_d;
  logic    exec_d;
  logic    rx_fire;

  assign rx_ready = (state_q != PS_SEND);
  assign rx_fire  = rx_valid && rx_ready;

  always_comb begin
    state_d   = state_q;
    resp_load = 1'b0;
    resp_sel  = RS_REV;
    hi_ld     = 1'b0;
    cnt_wr    = 1'b0;
    ctl_wr    = 1'b0;
    exec_d    = 1'b0;
    unique case (state_q)
      PS_IDLE: begin
        if (rx_fire) begin
          case (rx_data)
            OP_REV:   begin resp_load = 1'b1; resp_sel = RS_REV;  state_d = PS_SEND; end
            OP_RSTAT: begin resp_load = 1'b1; resp_sel = RS_STAT; state_d = PS_SEND; end
            OP_RCNT:  begin resp_load = 1'b1; resp_sel = RS_CNT;  state_d = PS_SEND; end
            OP_WCNT:  state_d = PS_CNT_HI;
            OP_WCTL:  state_d = PS_CTL;
            OP_EXEC:  exec_d  = 1'b1;
            default:  state_d = PS_IDLE;
          endcase
        end
      end
      PS_CNT_HI: if (rx_fire) begin hi_ld  = 1'b1; state_d = PS_CNT_LO; end
      PS_CNT_LO: if (rx_fire) begin cnt_wr = 1'b1; state_d = PS_IDLE;   end
      PS_CTL:    if (rx_fire) begin ctl_wr = 1'b1; state_d = PS_IDLE;   end
      PS_SEND:   if (tx_done) state_d = PS_IDLE;
      default:   state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PS_IDLE;
      exec_pulse <= 1'b0;
    end else begin
      state_q    <= state_d;
      exec_pulse <= exec_d;
    end
  end
endmodule

// File: rtl/dbg_cmd_regs.sv
module dbg_cmd_regs
  import dbg_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              hi_ld,
  input  logic              cnt_wr,
  input  logic              ctl_wr,
  input  logic              dbg_active,
  input  logic              rd_protect,
  input  logic [BYTE_W-1:0] stat_in,
  output logic [BYTE_W-1:0] ctl_q,
  output logic [WORD_W-1:0] cnt_q,
  output logic [BYTE_W-1:0] stat_q
);
  logic [BYTE_W-1:0] hi_q, ctl_d;
  logic              cnt_en;

  // The debug-mode bit sticks while the strap is set
  always_comb begin
    ctl_d = wr_data;
    if (rd_protect && ctl_q[DBG_BIT]) ctl_d[DBG_BIT] = 1'b1;
  end

  assign cnt_en = cnt_wr && dbg_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      ctl_q  <= '0;
      cnt_q  <= '0;
      stat_q <= '0;
    end else begin
      stat_q <= stat_in;
      if (hi_ld)  hi_q  <= wr_data;
      if (ctl_wr) ctl_q <= ctl_d;
      if (cnt_en) cnt_q <= {hi_q, wr_data};
    end
  end
endmodule

// File: rtl/dbg_cmd_resp.sv
module dbg_cmd_resp
  import dbg_cmd_pkg::*;
#(
  parameter logic [WORD_W-1:0] REV_VALUE = 16'h0102
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resp_load,
  input  rsel_e             resp_sel,
  input  logic              dbg_active,
  input  logic [BYTE_W-1:0] stat_q,
  input  logic [WORD_W-1:0] cnt_q,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_done
);
  logic [WORD_W-1:0] sh_q, sh_d, word;
  logic [LEFT_W-1:0] left_q, left_d, len;
  logic              tx_fire;

  always_comb begin
    unique case (resp_sel)
      RS_STAT: begin word = {stat_q, {BYTE_W{1'b0}}}; len = 2'd1; end
      RS_CNT:  begin word = dbg_active ? ~cnt_q : {WORD_W{1'b1}}; len = 2'd2; end
      default: begin word = REV_VALUE; len = 2'd2; end
    endcase
  end

  assign tx_valid = (left_q != '0);
  assign tx_data  = sh_q[WORD_W-1 -: BYTE_W];
  assign tx_fire  = tx_valid && tx_ready;
  assign tx_done  = tx_fire && (left_q == 2'd1);

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (resp_load) begin
      sh_d   = word;
      left_d = len;
    end else if (tx_fire) begin
      sh_d   = sh_q << BYTE_W;
      left_d = left_q - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/dbg_cmd_proc.sv
module dbg_cmd_proc
  import dbg_cmd_pkg::*;
#(
  parameter logic [15:0] REV_VALUE = 16'h0102
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        dbg_active,
  input  logic        rd_protect,
  input  logic [7:0]  stat_in,
  output logic [7:0]  ctl_q,
  output logic [15:0] cnt_q,
  output logic        exec_pulse
);
  logic [1:0] rs_q;
  logic       rst_sn;
  logic       tx_done, resp_load, hi_ld, cnt_wr, ctl_wr;
  rsel_e      resp_sel;
  logic [BYTE_W-1:0] stat_q;

  // Reset asserts at once and leaves two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  dbg_cmd_parser u_parser (
    .clk(clk), .rst_n(rst_sn), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_done(tx_done), .resp_load(resp_load),
    .resp_sel(resp_sel), .hi_ld(hi_ld), .cnt_wr(cnt_wr), .ctl_wr(ctl_wr),
    .exec_pulse(exec_pulse)
  );

  dbg_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_sn), .wr_data(rx_data), .hi_ld(hi_ld),
    .cnt_wr(cnt_wr), .ctl_wr(ctl_wr), .dbg_active(dbg_active),
    .rd_protect(rd_protect), .stat_in(stat_in), .ctl_q(ctl_q),
    .cnt_q(cnt_q), .stat_q(stat_q)
  );

  dbg_cmd_resp #(.REV_VALUE(REV_VALUE)) u_resp (
    .clk(clk), .rst_n(rst_sn), .resp_load(resp_load), .resp_sel(resp_sel),
    .dbg_active(dbg_active), .stat_q(stat_q), .cnt_q(cnt_q),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_done(tx_done)
  );
endmodule

// File: rtl/dbg_cmd_proc_chk.sv
module dbg_cmd_proc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_ready,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        dbg_active,
  input logic        rd_protect,
  input logic [7:0]  ctl_q,
  input logic [15:0] cnt_q,
  input logic        exec_pulse
);
  // R10: no byte is taken while a response is pending
  p_rx_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && tx_valid));

  // R10: a stalled response byte is held
  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R3: counter frozen outside debug mode
  p_cnt_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_active |=> $stable(cnt_q));

  // R7: protected debug-mode bit never falls
  p_dbg_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_protect && ctl_q[7]) |=> ctl_q[7]);

  // R8: execute strobe never overlaps a response
  p_exec_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_pulse |-> !tx_valid);
endmodule

bind dbg_cmd_proc dbg_cmd_proc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .dbg_active(dbg_active),
  .rd_protect(rd_protect), .ctl_q(ctl_q), .cnt_q(cnt_q),
  .exec_pulse(exec_pulse)
);

// File: tb/dbg_cmd_proc_test.sv
`timescale 1ns/1ps
module dbg_cmd_proc_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, rx_ready, tx_valid, tx_ready;
  logic [7:0]  rx_data, tx_data, stat_in, ctl_q;
  logic        dbg_active, rd_protect, exec_pulse;
  logic [15:0] cnt_q;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  dbg_cmd_proc uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .dbg_active(dbg_active), .rd_protect(rd_protect),
    .stat_in(stat_in), .ctl_q(ctl_q), .cnt_q(cnt_q), .exec_pulse(exec_pulse)
  );

  typedef struct packed {
    logic [7:0] op;
    logic [7:0] d0;
    logic [7:0] d1;
    logic       dbg;
    logic [1:0] n;
    logic [7:0] e0;
    logic [7:0] e1;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    '{8'h00, 8'h00, 8'h00, 1'b0, 2'd2, 8'h01, 8'h02}, // R2 revision
    '{8'h03, 8'h00, 8'h00, 1'b0, 2'd2, 8'hFF, 8'hFF}, // R5 outside debug
    '{8'h01, 8'h12, 8'h34, 1'b1, 2'd0, 8'h00, 8'h00}, // R3 load 1234
    '{8'h03, 8'h00, 8'h00, 1'b1, 2'd2, 8'hED, 8'hCB}, // R5 inverse
    '{8'h01, 8'hAB, 8'hCD, 1'b0, 2'd0, 8'h00, 8'h00}, // R3 dropped
    '{8'h03, 8'h00, 8'h00, 1'b1, 2'd2, 8'hED, 8'hCB}, // R3 unchanged
    '{8'h03, 8'h00, 8'h00, 1'b0, 2'd2, 8'hFF, 8'hFF}, // R5 substitution
    '{8'h02, 8'h00, 8'h00, 1'b0, 2'd1, 8'h5A, 8'h00}, // R4 status
    '{8'h07, 8'h00, 8'h00, 1'b1, 2'd0, 8'h00, 8'h00}, // R9 reserved
    '{8'hFF, 8'h00, 8'h00, 1'b1, 2'd0, 8'h00, 8'h00}, // R9 reserved
    '{8'h00, 8'h00, 8'h00, 1'b1, 2'd2, 8'h01, 8'h02}, // R9 parser idle again
    '{8'h01, 8'h00, 8'h00, 1'b1, 2'd0, 8'h00, 8'h00}, // R3 load 0000
    '{8'h03, 8'h00, 8'h00, 1'b1, 2'd2, 8'hFF, 8'hFF}  // R5 inverse of zero
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Starts and ends at a falling edge
  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_data  = b;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic recv(input int stall, output logic [7:0] b);
    logic [7:0] held;
    while (!tx_valid) @(negedge clk);
    held = tx_data;
    check(!rx_ready, "R10", int'(rx_ready), 0);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(tx_valid && tx_data == held, "R10", int'(tx_data), int'(held));
    end
    tx_ready = 1'b1;
    @(posedge clk);
    b = held;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic write_ctl(input logic [7:0] v);
    send(8'h04);
    send(v);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0; tx_ready = 1'b0;
    dbg_active = 1'b0; rd_protect = 1'b0; stat_in = 8'h5A;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ctl_q == 8'h00, "R1", ctl_q, 0);
    check(cnt_q == 16'h0000, "R1", cnt_q, 0);
    check(!tx_valid, "R1", tx_valid, 0);
    check(rx_ready, "R1", rx_ready, 1);
    check(!exec_pulse, "R1", exec_pulse, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      dbg_active = VT[i].dbg;
      send(VT[i].op);
      if (VT[i].op == 8'h01) begin send(VT[i].d0); send(VT[i].d1); end
      if (VT[i].op == 8'h04) send(VT[i].d0);
      if (VT[i].n >= 2'd1) begin
        recv(i % 3, b);
        check(b == VT[i].e0, $sformatf("vec%0d byte0", i), b, VT[i].e0);
      end
      if (VT[i].n == 2'd2) begin
        recv((i + 1) % 3, b);
        check(b == VT[i].e1, $sformatf("vec%0d byte1", i), b, VT[i].e1);
      end
      check(!tx_valid, $sformatf("vec%0d no extra byte R9", i), tx_valid, 0);
      check(rx_ready, $sformatf("vec%0d ready R10", i), rx_ready, 1);
    end

    // R3 counter port after dropped write
    dbg_active = 1'b0;
    send(8'h01); send(8'h55); send(8'h66);
    check(cnt_q == 16'h0000, "R3", cnt_q, 0);
    dbg_active = 1'b1;
    send(8'h01); send(8'hBE); send(8'hEF);
    check(cnt_q == 16'hBEEF, "R3", cnt_q, 16'hBEEF);

    // R6 control write outside debug mode
    dbg_active = 1'b0;
    write_ctl(8'h2C);
    check(ctl_q == 8'h2C, "R6", ctl_q, 8'h2C);

    // R7 unprotected bit clears
    rd_protect = 1'b0;
    write_ctl(8'h80);
    check(ctl_q == 8'h80, "R7", ctl_q, 8'h80);
    write_ctl(8'h11);
    check(ctl_q == 8'h11, "R7", ctl_q, 8'h11);

    // R7 protected bit sticks
    rd_protect = 1'b1;
    write_ctl(8'h03);
    check(ctl_q == 8'h03, "R7", ctl_q, 8'h03);
    write_ctl(8'h81);
    check(ctl_q == 8'h81, "R7", ctl_q, 8'h81);
    write_ctl(8'h00);
    check(ctl_q == 8'h80, "R7", ctl_q, 8'h80);
    write_ctl(8'h3C);
    check(ctl_q == 8'hBC, "R7", ctl_q, 8'hBC);

    // R8 execute strobe: high one cycle after acceptance, no response
    check(!exec_pulse, "R8", exec_pulse, 0);
    send(8'h12);
    check(exec_pulse, "R8", exec_pulse, 1);
    check(!tx_valid, "R8", tx_valid, 0);
    @(negedge clk);
    check(!exec_pulse, "R8", exec_pulse, 0);
    check(rx_ready && !tx_valid, "R8", tx_valid, 0);

    // R9 reserved opcode just below execute, then revision read still aligned
    send(8'h11);
    send(8'h00);
    recv(0, b);
    check(b == 8'h01, "R9", b, 8'h01);
    recv(0, b);
    check(b == 8'h02, "R9", b, 8'h02);

    // R1 reset leaves protected debug mode and clears the counter
    rst_n = 1'b0;
    @(negedge clk);
    check(ctl_q == 8'h00, "R1", ctl_q, 0);
    check(cnt_q == 16'h0000, "R1", cnt_q, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule